// File: doc/BRIEF.md
# Core Idle-State Sequencer

This block steps one processor core through three power levels: running, clock-stopped (C1) and power-removed (C6). A halt from the running core starts a C1 residency timer. When that timer expires with no interrupt pending, the sequencer asks the clocking agent to stop the core clock. If the core then stays idle long enough for a second residency timer to expire, it asks a save agent to write the architectural state out and flush it to the next cache level. After that it checks for interrupts again and only then asks the power agent to remove power. A wake interrupt brings the core back. From C1 that takes one clock-up request. From C6 it takes a power-up request and then a clock-up request.

Every request to an agent is a plain level that stays high until the matching acknowledge is sampled high on a clock edge. Only one request is outstanding at any time, so the clock-down and clock-up requests share one clock acknowledge. The acknowledge must be high for a single cycle. Both residency limits come from configuration inputs. A performance counter records each time the core actually reaches the clock-stopped state. A 2-bit status reports the current power level.

Top module: `cstate_seq`

## Requirements
- R1: While reset is held and right after it is released, all five request outputs are low, `cstate_o` is 0 (running) and `c1_count_o` is 0.
- R2: A halt sampled in the running state starts the C1 timer. The clock-down request rises on the (`c1_limit_i`+1)-th rising edge after the edge that sampled the halt. With the bench's sampling this is seen `c1_limit_i`+2 falling edges after the halt is driven.
- R3: If an interrupt is pending when the C1 timer expires, or a wake arrives during the C1 wait, the core returns to running and no request is issued.
- R4: A request stays high until its acknowledge is sampled, and falls on the edge that samples the acknowledge. At most one of the five requests is high at a time.
- R5: An acknowledged clock-down makes `cstate_o` equal 1 and adds exactly one to `c1_count_o`.
- R6: A wake in C1 raises the clock-up request on the next edge. Once that request is acknowledged, `cstate_o` returns to 0.
- R7: In C1, the save request rises on the (`c6_limit_i`+1)-th edge after the edge that sampled the clock-down acknowledge.
- R8: A save acknowledge with no pending interrupt and no wake raises the power-down request on that edge. Once power-down is acknowledged, `cstate_o` equals 2.
- R9: A save acknowledge while an interrupt is pending, or after a wake since the save began, leads straight to the clock-up request. No power-down request is issued.
- R10: A wake while power-down is outstanding leaves that request held. After its acknowledge, the power-up request follows, then the clock-up request.
- R11: A wake in C6 raises the power-up request on the next edge. `cstate_o` stays 2 until power-up is acknowledged. After that comes the clock-up request, and then running.
- R12: Each residency wait counts from zero on every entry. Repeated entries with the same limit give the same delay, and a limit of 0 gives a one-cycle wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_i | input | 1 | Core executed a halt |
| intr_pend_i | input | 1 | An interrupt is pending (level) |
| wake_i | input | 1 | Wake interrupt |
| c1_limit_i | input | LIM_W | C1 residency limit in cycles |
| c6_limit_i | input | LIM_W | C6 residency limit in cycles |
| clk_ack_i | input | 1 | Clocking agent acknowledge |
| save_ack_i | input | 1 | Save/flush agent acknowledge |
| pwr_ack_i | input | 1 | Power agent acknowledge |
| clk_dn_req_o | output | 1 | Request to stop the core clock |
| clk_up_req_o | output | 1 | Request to restart the core clock |
| save_req_o | output | 1 | Request to save state and flush |
| pwr_dn_req_o | output | 1 | Request to remove core power |
| pwr_up_req_o | output | 1 | Request to restore core power |
| cstate_o | output | 2 | 0 running, 1 clock-stopped, 2 power-removed |
| c1_count_o | output | PERF_W | Count of C1 entries |

## Verification
The bench measures both residency delays exactly, including a limit of 0. A timer that is off by one, or that keeps a stale count from an earlier entry, shows up as a wrong cycle count. It aborts at each of the abort points: an interrupt at the C1 timeout, a wake during the C1 wait, an interrupt at the save acknowledge, and a wake while power-down is outstanding. A design that skipped one of these checks would issue a clock-down or power-down it should not issue, or would settle in C6 with a wake already seen. It also pulses a wake while a request is held. A design that dropped the request early, or issued a second request at the same time, would be caught there.

// File: rtl/cstate_pkg.sv
package cstate_pkg;
  typedef enum logic [3:0] {
    ST_RUN,
    ST_C1_WAIT,
    ST_CLK_DN,
    ST_C1_RES,
    ST_SAVE,
    ST_PWR_DN,
    ST_C6_RES,
    ST_PWR_UP,
    ST_CLK_UP
  } seq_state_e;

  localparam logic [1:0] CS_RUN    = 2'd0;
  localparam logic [1:0] CS_CLKOFF = 2'd1;
  localparam logic [1:0] CS_PWROFF = 2'd2;

  localparam int NUM_TIMERS = 2;
  localparam int TMR_C1     = 0;
  localparam int TMR_C6     = 1;
endpackage

// File: rtl/cstate_res_timer.sv
module cstate_res_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q >= limit_i);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cstate_perf_ctr.sv
module cstate_perf_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     count_o <= '0;
    else if (inc_i) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/cstate_seq_fsm.sv
module cstate_seq_fsm
  import cstate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_i,
  input  logic       intr_pend_i,
  input  logic       wake_i,
  input  logic       clk_ack_i,
  input  logic       save_ack_i,
  input  logic       pwr_ack_i,
  input  logic       c1_exp_i,
  input  logic       c6_exp_i,
  output logic       c1_run_o,
  output logic       c6_run_o,
  output logic       c1_enter_o,
  output logic       clk_dn_req_o,
  output logic       clk_up_req_o,
  output logic       save_req_o,
  output logic       pwr_dn_req_o,
  output logic       pwr_up_req_o,
  output logic [1:0] cstate_o
);
  seq_state_e state_q, state_d;
  logic       wake_seen_q;
  logic       abort;

  // An interrupt or wake seen during save or power-down cancels C6 entry
  assign abort = intr_pend_i || wake_i || wake_seen_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:     if (halt_i) state_d = ST_C1_WAIT;
      ST_C1_WAIT: begin
        if (wake_i)        state_d = ST_RUN;
        else if (c1_exp_i) state_d = intr_pend_i ? ST_RUN : ST_CLK_DN;
      end
      ST_CLK_DN:  if (clk_ack_i) state_d = ST_C1_RES;
      ST_C1_RES: begin
        if (wake_i)        state_d = ST_CLK_UP;
        else if (c6_exp_i) state_d = ST_SAVE;
      end
      ST_SAVE:    if (save_ack_i) state_d = abort ? ST_CLK_UP : ST_PWR_DN;
      ST_PWR_DN:  if (pwr_ack_i)  state_d = abort ? ST_PWR_UP : ST_C6_RES;
      ST_C6_RES:  if (wake_i)     state_d = ST_PWR_UP;
      ST_PWR_UP:  if (pwr_ack_i)  state_d = ST_CLK_UP;
      ST_CLK_UP:  if (clk_ack_i)  state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      wake_seen_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_SAVE || state_q == ST_PWR_DN)
        wake_seen_q <= wake_seen_q || wake_i;
      else
        wake_seen_q <= 1'b0;
    end
  end

  assign c1_run_o     = (state_q == ST_C1_WAIT);
  assign c6_run_o     = (state_q == ST_C1_RES);
  assign clk_dn_req_o = (state_q == ST_CLK_DN);
  assign clk_up_req_o = (state_q == ST_CLK_UP);
  assign save_req_o   = (state_q == ST_SAVE);
  assign pwr_dn_req_o = (state_q == ST_PWR_DN);
  assign pwr_up_req_o = (state_q == ST_PWR_UP);
  assign c1_enter_o   = (state_q == ST_CLK_DN) && clk_ack_i;

  always_comb begin
    unique case (state_q)
      ST_C1_RES, ST_SAVE, ST_PWR_DN, ST_CLK_UP: cstate_o = CS_CLKOFF;
      ST_C6_RES, ST_PWR_UP:                     cstate_o = CS_PWROFF;
      default:                                  cstate_o = CS_RUN;
    endcase
  end
endmodule

// File: rtl/cstate_seq.sv
module cstate_seq
  import cstate_pkg::*;
#(
  parameter int LIM_W  = 8,
  parameter int PERF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_i,
  input  logic              intr_pend_i,
  input  logic              wake_i,
  input  logic [LIM_W-1:0]  c1_limit_i,
  input  logic [LIM_W-1:0]  c6_limit_i,
  input  logic              clk_ack_i,
  input  logic              save_ack_i,
  input  logic              pwr_ack_i,
  output logic              clk_dn_req_o,
  output logic              clk_up_req_o,
  output logic              save_req_o,
  output logic              pwr_dn_req_o,
  output logic              pwr_up_req_o,
  output logic [1:0]        cstate_o,
  output logic [PERF_W-1:0] c1_count_o
);
  logic [NUM_TIMERS-1:0] tmr_run, tmr_exp;
  logic [LIM_W-1:0]      tmr_lim [NUM_TIMERS];
  logic                  c1_enter;

  assign tmr_lim[TMR_C1] = c1_limit_i;
  assign tmr_lim[TMR_C6] = c6_limit_i;

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    cstate_res_timer #(.W(LIM_W)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (tmr_run[g]),
      .limit_i   (tmr_lim[g]),
      .expired_o (tmr_exp[g])
    );
  end

  cstate_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_i       (halt_i),
    .intr_pend_i  (intr_pend_i),
    .wake_i       (wake_i),
    .clk_ack_i    (clk_ack_i),
    .save_ack_i   (save_ack_i),
    .pwr_ack_i    (pwr_ack_i),
    .c1_exp_i     (tmr_exp[TMR_C1]),
    .c6_exp_i     (tmr_exp[TMR_C6]),
    .c1_run_o     (tmr_run[TMR_C1]),
    .c6_run_o     (tmr_run[TMR_C6]),
    .c1_enter_o   (c1_enter),
    .clk_dn_req_o (clk_dn_req_o),
    .clk_up_req_o (clk_up_req_o),
    .save_req_o   (save_req_o),
    .pwr_dn_req_o (pwr_dn_req_o),
    .pwr_up_req_o (pwr_up_req_o),
    .cstate_o     (cstate_o)
  );

  cstate_perf_ctr #(.W(PERF_W)) u_perf (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (c1_enter),
    .count_o (c1_count_o)
  );
endmodule

// File: rtl/cstate_seq_chk.sv
module cstate_seq_chk #(
  parameter int PERF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wake_i,
  input logic              clk_ack_i,
  input logic              save_ack_i,
  input logic              pwr_ack_i,
  input logic              clk_dn_req_o,
  input logic              clk_up_req_o,
  input logic              save_req_o,
  input logic              pwr_dn_req_o,
  input logic              pwr_up_req_o,
  input logic [1:0]        cstate_o,
  input logic [PERF_W-1:0] c1_count_o
);
  // R4
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clk_dn_req_o, clk_up_req_o, save_req_o, pwr_dn_req_o, pwr_up_req_o}));
  // R4
  clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_dn_req_o && !clk_ack_i) |=> clk_dn_req_o);
  // R4
  save_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req_o && !save_ack_i) |=> save_req_o);
  // R10
  pwr_dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn_req_o && !pwr_ack_i) |=> pwr_dn_req_o);
  // R11
  pwr_up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_up_req_o && !pwr_ack_i) |=> pwr_up_req_o);
  // R5
  perf_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_dn_req_o && clk_ack_i) |=> (c1_count_o == $past(c1_count_o) + 1'b1) && (cstate_o == 2'd1));
  // R6
  clk_up_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_up_req_o && clk_ack_i) |=> (cstate_o == 2'd0));
  // R8
  c6_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cstate_o == 2'd2 && $past(cstate_o) != 2'd2) |-> $past(pwr_dn_req_o && pwr_ack_i));
  // R11
  c6_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cstate_o == 2'd2 && !pwr_dn_req_o && !pwr_up_req_o && wake_i) |=> pwr_up_req_o);
  // R1
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cstate_o != 2'd3);
endmodule

bind cstate_seq cstate_seq_chk #(.PERF_W(PERF_W)) u_chk (.*);

// File: tb/cstate_seq_tb_top.sv
module cstate_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIM_W = 8;
  localparam int PERF_W = 16;
  localparam int NVEC = 9;
  localparam int B_CDN = 1, B_CUP = 2, B_SAVE = 4, B_PDN = 8, B_PUP = 16;

  // scenario codes: 0 abort at C1 timeout, 1 C1 then wake, 2 full C6 round trip,
  // 3 interrupt at save ack, 4 wake during power-down, 5 wake during C1 wait
  localparam logic [18:0] VEC [NVEC] = '{
    {3'd1, 8'd3,  8'd20},
    {3'd1, 8'd0,  8'd20},
    {3'd0, 8'd4,  8'd9},
    {3'd2, 8'd2,  8'd5},
    {3'd2, 8'd2,  8'd5},
    {3'd2, 8'd7,  8'd0},
    {3'd3, 8'd1,  8'd3},
    {3'd4, 8'd0,  8'd2},
    {3'd5, 8'd6,  8'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic halt_i = 0, intr_pend_i = 0, wake_i = 0;
  logic clk_ack_i = 0, save_ack_i = 0, pwr_ack_i = 0;
  logic [LIM_W-1:0] c1_limit_i = '0, c6_limit_i = '0;
  logic clk_dn_req_o, clk_up_req_o, save_req_o, pwr_dn_req_o, pwr_up_req_o;
  logic [1:0] cstate_o;
  logic [PERF_W-1:0] c1_count_o;
  int checks = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cstate_seq #(.LIM_W(LIM_W), .PERF_W(PERF_W)) dut_i (.*);

  wire [4:0] reqs = {pwr_up_req_o, pwr_dn_req_o, save_req_o, clk_up_req_o, clk_dn_req_o};

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_pulses();
    halt_i = 0; wake_i = 0; clk_ack_i = 0; save_ack_i = 0; pwr_ack_i = 0;
  endtask

  task automatic count_to_req(output int n);
    n = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      clear_pulses();
      n++;
      if (reqs != 0) break;
    end
  endtask

  task automatic expect_req(input int exp_bits, input int exp_n, input string tag);
    int n;
    count_to_req(n);
    chk(reqs == exp_bits[4:0], {tag, " request"}, reqs, exp_bits);
    chk(n == exp_n, {tag, " delay"}, n, exp_n);
  endtask

  task automatic ack_idle(input int which);
    if (which == 0) clk_ack_i = 1; else if (which == 1) save_ack_i = 1; else pwr_ack_i = 1;
    @(negedge clk);
    clear_pulses();
  endtask

  task automatic quiet(input int ncyc, input string tag);
    logic seen = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      clear_pulses();
      if (reqs != 0) seen = 1;
    end
    chk(!seen && cstate_o == 2'd0, tag, cstate_o, 0);
  endtask

  task automatic run_vec(input logic [2:0] sc, input int c1, input int c6);
    int p0;
    p0 = c1_count_o;
    c1_limit_i = c1[LIM_W-1:0];
    c6_limit_i = c6[LIM_W-1:0];
    if (sc == 0) begin
      intr_pend_i = 1; halt_i = 1;
      quiet(c1 + 6, "R3 abort at C1 timeout");
      intr_pend_i = 0;
      chk(c1_count_o == p0[PERF_W-1:0], "R3 perf unchanged", c1_count_o, p0);
      return;
    end
    if (sc == 5) begin
      halt_i = 1;
      @(negedge clk); clear_pulses();
      wake_i = 1;
      quiet(c1 + 6, "R3 wake during C1 wait");
      return;
    end
    halt_i = 1;
    expect_req(B_CDN, c1 + 2, "R2 R12 clock-down");
    if (sc == 1) begin
      ack_idle(0);
      chk(cstate_o == 2'd1, "R5 status C1", cstate_o, 1);
      chk(c1_count_o == p0[PERF_W-1:0] + 1'b1, "R5 perf", c1_count_o, p0 + 1);
      halt_i = 1;
      @(negedge clk); clear_pulses();
      chk(reqs == 0 && cstate_o == 2'd1, "R4 halt ignored in C1", reqs, 0);
      wake_i = 1;
      expect_req(B_CUP, 1, "R6 clock-up");
      ack_idle(0);
      chk(cstate_o == 2'd0 && reqs == 0, "R6 back to running", cstate_o, 0);
      return;
    end
    clk_ack_i = 1;
    expect_req(B_SAVE, c6 + 2, "R7 R12 save");
    if (sc == 3) begin
      intr_pend_i = 1; save_ack_i = 1;
      expect_req(B_CUP, 1, "R9 skip power-down");
      intr_pend_i = 0;
      chk(cstate_o == 2'd1, "R9 status stays C1", cstate_o, 1);
      ack_idle(0);
      chk(cstate_o == 2'd0, "R9 back to running", cstate_o, 0);
      return;
    end
    save_ack_i = 1;
    expect_req(B_PDN, 1, "R8 power-down");
    if (sc == 4) begin
      wake_i = 1;
      @(negedge clk); clear_pulses();
      chk(reqs == B_PDN, "R10 power-down held", reqs, B_PDN);
      pwr_ack_i = 1;
      expect_req(B_PUP, 1, "R10 power-up after abort");
      chk(cstate_o == 2'd2, "R10 status during power-up", cstate_o, 2);
    end else begin
      ack_idle(2);
      chk(cstate_o == 2'd2 && reqs == 0, "R8 status C6", cstate_o, 2);
      repeat (3) @(negedge clk);
      chk(cstate_o == 2'd2, "R11 stays in C6", cstate_o, 2);
      wake_i = 1;
      expect_req(B_PUP, 1, "R11 power-up");
    end
    pwr_ack_i = 1;
    expect_req(B_CUP, 1, "R11 clock-up after power-up");
    ack_idle(0);
    chk(cstate_o == 2'd0 && reqs == 0, "R11 back to running", cstate_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(reqs == 0 && cstate_o == 2'd0 && c1_count_o == 0, "R1 in reset", reqs, 0);
    rst_n = 1;
    @(negedge clk);
    chk(reqs == 0 && cstate_o == 2'd0 && c1_count_o == 0, "R1 after reset", cstate_o, 0);

    for (int v = 0; v < NVEC; v++) begin
      run_vec(VEC[v][18:16], int'(VEC[v][15:8]), int'(VEC[v][7:0]));
      repeat (2) @(negedge clk);
    end

    // R12: limit changed between entries, count restarts from zero
    c1_limit_i = 8'd5;
    halt_i = 1;
    expect_req(B_CDN, 7, "R12 fresh count");
    clk_ack_i = 1;
    c6_limit_i = 8'd1;
    expect_req(B_SAVE, 3, "R12 fresh C6 count");

    // R1: reset in the middle of a sequence
    rst_n = 0;
    @(negedge clk);
    chk(reqs == 0 && cstate_o == 2'd0 && c1_count_o == 0, "R1 mid-flow reset", reqs, 0);
    rst_n = 1;
    @(negedge clk);
    chk(reqs == 0 && cstate_o == 2'd0, "R1 idle after reset", cstate_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule